// File: doc/BRIEF.md
# Clear-Channel Window Interrupt with Persistence Filter

This block watches the stream of completed clear-channel light measurements and decides when the host should be interrupted. Each result arrives with a one-cycle valid strobe. The block compares it against a programmable low and high limit, and counts how many out-of-window results have arrived back to back. A 4-bit persistence code sets how long that run must be before the interrupt is raised.

Once raised, the interrupt status stays set until the host issues a one-cycle clear command. The status bit always tracks this latched state. The external pin is active-low and open-drain, and it is pulled low only while the output enable is set.

The result input has no back-pressure. The block accepts every cycle in which `res_valid` is high, so the producer never has to wait. Cycles in which `res_valid` is low are not evaluated.

Top module: `lux_window_irq`

## Requirements
- R1: After reset, `irq_status` is 0, `irq_pad_oe` is 0, `irq_n` is 1, and the consecutive-run counter is zero.
- R2: A result is out of window only when it is strictly below `thr_lo` or strictly above `thr_hi`. A result equal to either limit counts as in window.
- R3: With `pers_code` = 0, every accepted result sets `irq_status`, whatever its value.
- R4: With `pers_code` 1, 2 or 3, that many consecutive out-of-window results are needed. Codes 4 to 15 need 5×(code−3) results, which gives 5, 10, 15 and so on up to 60 at code 15.
- R5: An accepted in-window result resets the run counter to zero.
- R6: The run counter keeps counting past the required length and saturates at its maximum. After a clear, the next out-of-window result in an unbroken run sets the status again at once.
- R7: `irq_status` changes one cycle after the accepting clock edge. Once set, it holds until `irq_clr` is high on a clock edge, and it reads 0 in the following cycle.
- R8: If a clear and a new trigger meet on the same edge, the status stays set.
- R9: `irq_pad_oe` equals `irq_status` AND `irq_en`, and `irq_n` is its inverse. Both follow `irq_en` in the same cycle, and `irq_en` has no effect on `irq_status`.
- R10: In a cycle with `res_valid` low, the data and limit inputs have no effect on the counter or on the status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| res_valid | input | 1 | Marks a completed result on `res_data`; always accepted |
| res_data | input | 16 | Clear-channel result |
| thr_lo | input | 16 | Low window limit |
| thr_hi | input | 16 | High window limit |
| pers_code | input | 4 | Persistence code (see R3, R4) |
| irq_en | input | 1 | Enables driving of the interrupt pin |
| irq_clr | input | 1 | One-cycle interrupt clear command |
| irq_status | output | 1 | Latched interrupt status |
| irq_pad_oe | output | 1 | 1 pulls the open-drain pad low |
| irq_n | output | 1 | Active-low interrupt level |

## Verification
The bench runs results that sit exactly on each limit. A design that compared inclusively would count those and fire early. Runs stop one short of the required length and are also broken by a single in-window result, which exposes a wrong mapping from persistence code to count, or a counter that is not reset. A clear is issued on the same edge as a trigger, where a design that lets the clear win would drop the interrupt. Idle cycles carry out-of-window data, which a design that ignores the strobe would count. The enable is toggled while the status is held, to show that the pin follows it and the status does not.

// File: rtl/lux_irq_pkg.sv
package lux_irq_pkg;
  localparam int CODE_W = 4;
  localparam int RUN_W  = 6;   // holds the longest run of 60

  // Number of consecutive out-of-window results each code needs; 0 means every result.
  function automatic logic [RUN_W-1:0] run_needed(input logic [CODE_W-1:0] code);
    logic [RUN_W-1:0] r;
    if (code <= 4'd3) r = RUN_W'(code);
    else              r = RUN_W'(5 * (int'(code) - 3));
    return r;
  endfunction
endpackage

// File: rtl/lux_window_cmp.sv
module lux_window_cmp #(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0] value,
  input  logic [DATA_W-1:0] lo,
  input  logic [DATA_W-1:0] hi,
  output logic              outside
);
  logic below, above;
  always_comb begin
    below   = value < lo;
    above   = value > hi;
    outside = below | above;
  end
endmodule

// File: rtl/lux_persist_filter.sv
module lux_persist_filter
  import lux_irq_pkg::*;
#(
  parameter int RW = RUN_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic              outside,
  input  logic [CODE_W-1:0] code,
  output logic              fire
);
  localparam logic [RW-1:0] RUN_MAX = {RW{1'b1}};

  logic [RW-1:0] run_q, run_inc;

  always_comb begin
    run_inc = (run_q == RUN_MAX) ? run_q : run_q + 1'b1;
    fire    = 1'b0;
    if (take) begin
      if (code == '0)  fire = 1'b1;
      else if (outside) fire = (run_inc >= RW'(run_needed(code)));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     run_q <= '0;
    else if (take)  run_q <= outside ? run_inc : '0;
  end
endmodule

// File: rtl/lux_irq_latch.sv
module lux_irq_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  input  logic en,
  output logic status,
  output logic pad_oe,
  output logic pin_n
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   status <= 1'b0;
    else if (set) status <= 1'b1;   // a new trigger beats a clear on the same edge
    else if (clr) status <= 1'b0;
  end

  always_comb begin
    pad_oe = status & en;
    pin_n  = ~pad_oe;
  end
endmodule

// File: rtl/lux_window_irq.sv
module lux_window_irq
  import lux_irq_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              res_valid,
  input  logic [DATA_W-1:0] res_data,
  input  logic [DATA_W-1:0] thr_lo,
  input  logic [DATA_W-1:0] thr_hi,
  input  logic [CODE_W-1:0] pers_code,
  input  logic              irq_en,
  input  logic              irq_clr,
  output logic              irq_status,
  output logic              irq_pad_oe,
  output logic              irq_n
);
  logic outside, fire;

  lux_window_cmp #(.DATA_W(DATA_W)) u_cmp (
    .value(res_data), .lo(thr_lo), .hi(thr_hi), .outside(outside)
  );

  lux_persist_filter #(.RW(RUN_W)) u_filt (
    .clk(clk), .rst_n(rst_n), .take(res_valid), .outside(outside),
    .code(pers_code), .fire(fire)
  );

  lux_irq_latch u_latch (
    .clk(clk), .rst_n(rst_n), .set(fire), .clr(irq_clr), .en(irq_en),
    .status(irq_status), .pad_oe(irq_pad_oe), .pin_n(irq_n)
  );
endmodule

// File: rtl/lux_window_irq_chk.sv
module lux_window_irq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       res_valid,
  input logic [3:0] pers_code,
  input logic       irq_en,
  input logic       irq_clr,
  input logic       irq_status,
  input logic       irq_pad_oe,
  input logic       irq_n
);
  assert_code0_fires_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && pers_code == 4'd0) |=> irq_status);

  assert_set_beats_clr_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && pers_code == 4'd0 && irq_clr) |=> irq_status);

  assert_fall_needs_clr_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_status) |-> $past(irq_clr));

  assert_idle_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!res_valid && !irq_clr) |=> $stable(irq_status));

  assert_rise_needs_valid_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_status) |-> $past(res_valid));

  assert_pad_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pad_oe |-> (irq_status && irq_en));

  assert_pin_polarity_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_n == !irq_pad_oe);
endmodule

bind lux_window_irq lux_window_irq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .res_valid(res_valid), .pers_code(pers_code),
  .irq_en(irq_en), .irq_clr(irq_clr), .irq_status(irq_status),
  .irq_pad_oe(irq_pad_oe), .irq_n(irq_n)
);

// File: tb/lux_window_irq_tb.sv
`timescale 1ns/1ps
module lux_window_irq_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        res_valid = 1'b0;
  logic [15:0] res_data = '0, thr_lo = '0, thr_hi = '0;
  logic [3:0]  pers_code = '0;
  logic        irq_en = 1'b0, irq_clr = 1'b0;
  logic        irq_status, irq_pad_oe, irq_n;

  int checks = 0;
  int errors = 0;
  int m_run = 0;
  bit m_stat = 1'b0;

  always #4 clk = ~clk;

  lux_window_irq u_dut (
    .clk(clk), .rst_n(rst_n), .res_valid(res_valid), .res_data(res_data),
    .thr_lo(thr_lo), .thr_hi(thr_hi), .pers_code(pers_code), .irq_en(irq_en),
    .irq_clr(irq_clr), .irq_status(irq_status), .irq_pad_oe(irq_pad_oe), .irq_n(irq_n)
  );

  function automatic int need_of(input int code);
    int t[16] = '{0, 1, 2, 3, 5, 10, 15, 20, 25, 30, 35, 40, 45, 50, 55, 60};
    return t[code];
  endfunction

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic chk_all(input string req);
    chk(req, irq_status, m_stat);
    chk(req, irq_pad_oe, m_stat & irq_en);
    chk(req, irq_n, ~(m_stat & irq_en));
  endtask

  // drive at a falling edge, update the model at the rising edge, sample at the next falling edge
  task automatic step(input bit v, input logic [15:0] d, input bit c, input string req);
    bit outside, trig;
    res_valid = v; res_data = d; irq_clr = c;
    @(posedge clk);
    outside = (d < thr_lo) || (d > thr_hi);
    trig = 1'b0;
    if (v) begin
      if (outside) m_run = (m_run == 63) ? 63 : m_run + 1; else m_run = 0;
      if (pers_code == 0) trig = 1'b1;
      else if (outside && m_run >= need_of(pers_code)) trig = 1'b1;
    end
    if (trig) m_stat = 1'b1; else if (c) m_stat = 1'b0;
    @(negedge clk);
    res_valid = 1'b0; irq_clr = 1'b0;
    chk_all(req);
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int seed = 1234;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    chk_all("R1 reset");
    rst_n = 1'b1;
    @(negedge clk);
    chk_all("R1 after release");

    thr_lo = 16'd100; thr_hi = 16'd200; irq_en = 1'b1;
    // R2: values on the limits are in window
    pers_code = 4'd1;
    step(1, 16'd100, 0, "R2 equal low");
    step(1, 16'd200, 0, "R2 equal high");
    step(1, 16'd99, 0, "R2 below low");
    step(0, 0, 1, "R7 clear");
    step(1, 16'd201, 0, "R2 above high");
    step(0, 0, 1, "R7 clear");
    step(1, 16'd150, 0, "R5 reset run");
    // R3: code 0 fires on in-window data
    pers_code = 4'd0;
    step(1, 16'd150, 0, "R3 code zero");
    step(0, 16'd5, 0, "R7 hold");
    step(0, 16'd5, 0, "R10 idle");
    step(0, 0, 1, "R7 clear");
    // R4: code 5 needs 10 consecutive results
    pers_code = 4'd5;
    step(1, 16'd150, 0, "R5 reset run");
    for (int i = 0; i < 9; i++) step(1, 16'd300, 0, "R4 below count");
    step(0, 16'd300, 0, "R10 idle not counted");
    step(1, 16'd300, 0, "R4 tenth fires");
    // R6: unbroken run keeps firing after a clear
    step(0, 0, 1, "R7 clear");
    step(1, 16'd1, 0, "R6 continued run");
    // R8: clear on the same edge as a trigger
    step(1, 16'd1, 1, "R8 set beats clear");
    // R9: enable gates only the pin
    irq_en = 1'b0; #1 chk_all("R9 enable off");
    irq_en = 1'b1; #1 chk_all("R9 enable on");
    step(0, 0, 1, "R7 clear");
    // R5: an in-window result breaks the run
    pers_code = 4'd2;
    step(1, 16'd150, 0, "R5 reset run");
    step(1, 16'd300, 0, "R4 code2 first");
    step(1, 16'd150, 0, "R5 break");
    step(1, 16'd300, 0, "R5 restart one");
    step(1, 16'd300, 0, "R4 code2 fires");
    step(0, 0, 1, "R7 clear");
    // R4: code 15 needs 60
    pers_code = 4'd15;
    step(1, 16'd150, 0, "R5 reset run");
    for (int i = 0; i < 59; i++) step(1, 16'd50, 0, "R4 code15 short");
    step(1, 16'd50, 0, "R4 code15 fires");
    step(0, 0, 1, "R7 clear");

    // random mix
    for (int i = 0; i < 3000; i++) begin
      if ($urandom_range(0, 40) == 0) pers_code = 4'($urandom_range(0, 15));
      if ($urandom_range(0, 30) == 0) irq_en = 1'($urandom_range(0, 1));
      if ($urandom_range(0, 200) == 0) begin
        thr_lo = 16'($urandom_range(0, 30000));
        thr_hi = thr_lo + 16'($urandom_range(0, 30000));
      end
      step(1'($urandom_range(0, 3) != 0),
           ($urandom_range(0, 3) == 0) ? thr_lo + 16'($urandom_range(0, 2)) : 16'($urandom()),
           1'($urandom_range(0, 15) == 0), "R4 random");
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule